// File: doc/BRIEF.md
# Programmable-Timing External Memory Bus Controller

This block connects a single-request internal port to an asynchronous parallel memory bus. The bus has six active-low chip selects, a 9-bit address, a 16-bit data path with a separate output enable, and active-low output-enable, write-strobe and address-valid lines. The block accepts one request at a time through a valid/ready handshake and runs it on the bus. The bus cycle has a setup phase, a strobe phase and, for writes, a hold phase. A read returns its data with a one-cycle response pulse, and a write signals completion with the same pulse.

Each chip select has its own timing set, loaded through a simple configuration write port. The set holds the read and write wait states, the read and write first-access latencies, the write hold, the bus turnaround recovery, the read setup length, the address-valid to output-enable spacing and an address-hold extension. A per-select first-access flag decides whether the first-access latency is added. The block inserts a quiet turnaround gap only when a read is followed by an access to another chip select, or by a write to the same one.

Top module: `xbus_ctrl`

## Requirements
- R1: At most one chip select is low at a time. Chip select c drives bit c of `bus_cs_n` low, and only while an access to c is in its setup, strobe or hold phase.
- R2: A read holds its chip select low for max(read_hold, adv_to_oe) + addr_hold cycles before output enable falls.
- R3: The read output enable stays low for read_wait + 1 cycles. When the first-access flag of that chip select is set, read_first is added.
- R4: The write strobe stays low for write_wait + 1 cycles. When the first-access flag is set, write_first is added. A write has no setup phase.
- R5: After the write strobe rises, the chip select stays low for write_hold + 1 more cycles. During this span the write data and the data output enable stay driven.
- R6: Recovery cycles, with every chip select high and no data driven, come between acceptance and the access in two cases: after a read, when the next access targets another chip select, and after a read, when the next access is a write to the same chip select. The count is the recovery field of the chip select that was read, and a value of 0 gives 1 cycle. No other sequence has recovery cycles.
- R7: Reset sets the first-access flag of every chip select. When an access completes, the flag of its own chip select is cleared and the flags of all other chip selects are set.
- R8: Address valid is low for exactly one cycle per access, in the first cycle in which the chip select is low.
- R9: The data output enable is high only during the strobe and hold phases of a write. Write data is on `bus_dout` and the address is on `bus_addr` throughout the access.
- R10: Read data is sampled in the last output-enable cycle. It is presented on `rsp_rdata` with `rsp_valid` high for exactly one cycle, in the first cycle after the chip select rises. Writes also pulse `rsp_valid` at completion.
- R11: `req_ready` is low from the cycle after acceptance until the cycle in which `rsp_valid` pulses. That is the cycle after the recovery, setup, strobe and hold phases.
- R12: A configuration write with `cfg_we` high stores the low bits of `cfg_value` into one field of chip select `cfg_cs`. The field codes are: 0 read_wait, 1 write_wait, 2 read_first, 3 write_first, 4 recovery, 5 write_hold, 6 read_hold, 7 adv_to_oe, 8 addr_hold. A write with `cfg_cs` 6 or 7 changes nothing.
- R13: After reset all chip selects, output enable, write strobe and address valid are high, the data output enable and `rsp_valid` are low, `req_ready` is high, and every timing field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted when valid |
| req_write | input | 1 | 1 for write, 0 for read |
| req_cs | input | 3 | Target chip select index, 0 to 5 |
| req_addr | input | 9 | Word address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data captured from the bus |
| cfg_we | input | 1 | Timing field write strobe |
| cfg_cs | input | 3 | Chip select whose timing is written |
| cfg_field | input | 4 | Field code, see R12 |
| cfg_value | input | 8 | Field value, low bits used |
| bus_cs_n | output | 6 | Active-low chip selects |
| bus_addr | output | 9 | External address |
| bus_dout | output | 16 | External write data |
| bus_doe | output | 1 | Data output enable for the pad drivers |
| bus_din | input | 16 | External read data |
| bus_oe_n | output | 1 | Active-low output enable |
| bus_we_n | output | 1 | Active-low write strobe |
| bus_adv_n | output | 1 | Active-low address valid |

## Verification
The assertions assume three things about the inputs. Requests name only chip selects 0 to 5. No timing field of a chip select is rewritten while an access or a pending recovery on it is in progress. The memory holds `bus_din` stable while output enable is low. The bench writes the configuration only between accesses, when the controller is idle, and uses only valid chip-select indices in requests. Its memory model drives a known word as a function of the address whenever output enable is low, and a distinct filler value otherwise. A capture outside the output-enable window therefore shows up as a data mismatch.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  localparam int CNT_W = 9;

  localparam logic [3:0] FLD_RD_WAIT   = 4'd0;
  localparam logic [3:0] FLD_WR_WAIT   = 4'd1;
  localparam logic [3:0] FLD_RD_FIRST  = 4'd2;
  localparam logic [3:0] FLD_WR_FIRST  = 4'd3;
  localparam logic [3:0] FLD_RECOV     = 4'd4;
  localparam logic [3:0] FLD_WR_HOLD   = 4'd5;
  localparam logic [3:0] FLD_RD_HOLD   = 4'd6;
  localparam logic [3:0] FLD_ADV_OE    = 4'd7;
  localparam logic [3:0] FLD_ADDR_HOLD = 4'd8;

  typedef struct packed {
    logic [3:0] rd_wait;
    logic [3:0] wr_wait;
    logic [7:0] rd_first;
    logic [7:0] wr_first;
    logic [3:0] recov;
    logic [3:0] wr_hold;
    logic [3:0] rd_hold;
    logic [1:0] adv_oe;
    logic       addr_hold;
  } cs_timing_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RECOV, ST_SETUP, ST_STROBE, ST_WHOLD
  } seq_state_e;

  // cycles from chip select low to output enable low on a read
  function automatic logic [CNT_W-1:0] setup_cycles(cs_timing_t t);
    logic [CNT_W-1:0] a;
    logic [CNT_W-1:0] b;
    a = CNT_W'(t.rd_hold);
    b = CNT_W'(t.adv_oe);
    return ((a > b) ? a : b) + CNT_W'(t.addr_hold);
  endfunction

  // strobe width: wait states plus one, plus first-access latency when flagged
  function automatic logic [CNT_W-1:0] strobe_cycles(logic [3:0] wait_st,
                                                     logic [7:0] first_lat,
                                                     logic       is_first);
    return CNT_W'(wait_st) + CNT_W'(1) + (is_first ? CNT_W'(first_lat) : CNT_W'(0));
  endfunction

  // turnaround gap, never shorter than one cycle
  function automatic logic [CNT_W-1:0] recov_cycles(logic [3:0] r);
    return (r == 4'd0) ? CNT_W'(1) : CNT_W'(r);
  endfunction

  function automatic logic [CNT_W-1:0] hold_cycles(logic [3:0] h);
    return CNT_W'(h) + CNT_W'(1);
  endfunction

endpackage

// File: rtl/xbus_timing_regs.sv
module xbus_timing_regs
  import xbus_pkg::*;
#(
  parameter int NUM_CS = 6,
  parameter int CS_W   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [CS_W-1:0] cfg_cs,
  input  logic [3:0]      cfg_field,
  input  logic [7:0]      cfg_value,
  input  logic [CS_W-1:0] look_idx,
  output cs_timing_t      look_cfg
);

  cs_timing_t tim [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    cs_timing_t r;
    wire hit = cfg_we && (cfg_cs == CS_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r <= '0;
      end else if (hit) begin
        case (cfg_field)
          FLD_RD_WAIT:   r.rd_wait   <= cfg_value[3:0];
          FLD_WR_WAIT:   r.wr_wait   <= cfg_value[3:0];
          FLD_RD_FIRST:  r.rd_first  <= cfg_value;
          FLD_WR_FIRST:  r.wr_first  <= cfg_value;
          FLD_RECOV:     r.recov     <= cfg_value[3:0];
          FLD_WR_HOLD:   r.wr_hold   <= cfg_value[3:0];
          FLD_RD_HOLD:   r.rd_hold   <= cfg_value[3:0];
          FLD_ADV_OE:    r.adv_oe    <= cfg_value[1:0];
          FLD_ADDR_HOLD: r.addr_hold <= cfg_value[0];
          default: ;
        endcase
      end
    end
    assign tim[g] = r;
  end

  always_comb begin
    look_cfg = '0;
    for (int i = 0; i < NUM_CS; i++)
      if (look_idx == CS_W'(i)) look_cfg = tim[i];
  end

endmodule

// File: rtl/xbus_first_track.sv
module xbus_first_track #(
  parameter int NUM_CS = 6,
  parameter int CS_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [CS_W-1:0]   done_cs,
  output logic [NUM_CS-1:0] first_vec
);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    first_vec[g] <= 1'b1;
      else if (done) first_vec[g] <= (done_cs != CS_W'(g));
    end
  end

  AST_FIRST_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !first_vec[$past(done_cs)]); // R7

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int NUM_CS = 6,
  parameter int CS_W   = 3,
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [CS_W-1:0]   req_cs,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [CS_W-1:0]   look_idx,
  input  cs_timing_t        look_cfg,
  input  logic [NUM_CS-1:0] first_vec,
  output logic              done,
  output logic [CS_W-1:0]   done_cs,
  output logic [NUM_CS-1:0] bus_cs_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [DATA_W-1:0] bus_din,
  output logic              bus_oe_n,
  output logic              bus_we_n,
  output logic              bus_adv_n
);

  seq_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic              cur_wr;
  logic [CS_W-1:0]   cur_cs;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;
  logic              adv_q;
  logic              last_rd;
  logic [CS_W-1:0]   last_cs;
  logic [3:0]        last_recov;

  // named events for the assertions
  wire idle      = (state == ST_IDLE);
  wire accept    = idle && req_valid;
  wire need_turn = last_rd && ((req_cs != last_cs) || req_write);
  wire active    = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_WHOLD);
  wire strobe_end = (state == ST_STROBE) && (cnt == '0);
  wire hold_end   = (state == ST_WHOLD) && (cnt == '0);

  assign look_idx = idle ? req_cs : cur_cs;
  wire act_wr     = idle ? req_write : cur_wr;

  logic act_first;
  always_comb begin
    act_first = 1'b0;
    for (int i = 0; i < NUM_CS; i++)
      if (look_idx == CS_W'(i)) act_first = first_vec[i];
  end

  wire [CNT_W-1:0] rd_setup  = setup_cycles(look_cfg);
  wire [CNT_W-1:0] rd_strobe = strobe_cycles(look_cfg.rd_wait, look_cfg.rd_first, act_first);
  wire [CNT_W-1:0] wr_strobe = strobe_cycles(look_cfg.wr_wait, look_cfg.wr_first, act_first);

  seq_state_e      start_state;
  logic [CNT_W-1:0] start_cnt;
  always_comb begin
    if (act_wr) begin
      start_state = ST_STROBE;
      start_cnt   = wr_strobe - CNT_W'(1);
    end else if (rd_setup != '0) begin
      start_state = ST_SETUP;
      start_cnt   = rd_setup - CNT_W'(1);
    end else begin
      start_state = ST_STROBE;
      start_cnt   = rd_strobe - CNT_W'(1);
    end
  end

  assign done    = (strobe_end && !cur_wr) || hold_end;
  assign done_cs = cur_cs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      cur_wr     <= 1'b0;
      cur_cs     <= '0;
      cur_addr   <= '0;
      cur_wdata  <= '0;
      adv_q      <= 1'b0;
      last_rd    <= 1'b0;
      last_cs    <= '0;
      last_recov <= '0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      adv_q     <= 1'b0;
      if (done) begin
        last_rd    <= !cur_wr;
        last_cs    <= cur_cs;
        last_recov <= look_cfg.recov;
      end
      case (state)
        ST_IDLE: if (accept) begin
          cur_wr    <= req_write;
          cur_cs    <= req_cs;
          cur_addr  <= req_addr;
          cur_wdata <= req_wdata;
          if (need_turn) begin
            state <= ST_RECOV;
            cnt   <= recov_cycles(last_recov) - CNT_W'(1);
          end else begin
            state <= start_state;
            cnt   <= start_cnt;
            adv_q <= 1'b1;
          end
        end
        ST_RECOV: begin
          if (cnt == '0) begin
            state <= start_state;
            cnt   <= start_cnt;
            adv_q <= 1'b1;
          end else cnt <= cnt - CNT_W'(1);
        end
        ST_SETUP: begin
          if (cnt == '0) begin
            state <= ST_STROBE;
            cnt   <= rd_strobe - CNT_W'(1);
          end else cnt <= cnt - CNT_W'(1);
        end
        ST_STROBE: begin
          if (cnt == '0) begin
            if (cur_wr) begin
              state <= ST_WHOLD;
              cnt   <= hold_cycles(look_cfg.wr_hold) - CNT_W'(1);
            end else begin
              state     <= ST_IDLE;
              rsp_rdata <= bus_din;
              rsp_valid <= 1'b1;
            end
          end else cnt <= cnt - CNT_W'(1);
        end
        ST_WHOLD: begin
          if (cnt == '0) begin
            state     <= ST_IDLE;
            rsp_valid <= 1'b1;
          end else cnt <= cnt - CNT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = idle;
  for (genvar g = 0; g < NUM_CS; g++) begin : g_csn
    assign bus_cs_n[g] = !(active && (cur_cs == CS_W'(g)));
  end
  assign bus_addr  = cur_addr;
  assign bus_dout  = cur_wdata;
  assign bus_doe   = active && cur_wr;
  assign bus_oe_n  = !((state == ST_STROBE) && !cur_wr);
  assign bus_we_n  = !((state == ST_STROBE) && cur_wr);
  assign bus_adv_n = !adv_q;

  AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n)); // R1
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !(&bus_cs_n) |-> !req_ready); // R11
  AST_DOE_NOT_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> bus_oe_n); // R9
  AST_RECOV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RECOV) |-> ((&bus_cs_n) && !bus_doe)); // R6
  AST_ADV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_adv_n |=> bus_adv_n); // R8
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R10
  AST_WHOLD_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WHOLD) |-> (bus_we_n && bus_doe && !(&bus_cs_n))); // R5

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int NUM_CS = 6,
  parameter int CS_W   = 3,
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [CS_W-1:0]   req_cs,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              cfg_we,
  input  logic [CS_W-1:0]   cfg_cs,
  input  logic [3:0]        cfg_field,
  input  logic [7:0]        cfg_value,
  output logic [NUM_CS-1:0] bus_cs_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [DATA_W-1:0] bus_din,
  output logic              bus_oe_n,
  output logic              bus_we_n,
  output logic              bus_adv_n
);

  logic [CS_W-1:0]   look_idx;
  cs_timing_t        look_cfg;
  logic [NUM_CS-1:0] first_vec;
  logic              done;
  logic [CS_W-1:0]   done_cs;

  xbus_timing_regs #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_cs(cfg_cs), .cfg_field(cfg_field), .cfg_value(cfg_value),
    .look_idx(look_idx), .look_cfg(look_cfg)
  );

  xbus_first_track #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_first (
    .clk(clk), .rst_n(rst_n), .done(done), .done_cs(done_cs), .first_vec(first_vec)
  );

  xbus_seq #(.NUM_CS(NUM_CS), .CS_W(CS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .look_idx(look_idx), .look_cfg(look_cfg), .first_vec(first_vec),
    .done(done), .done_cs(done_cs),
    .bus_cs_n(bus_cs_n), .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .bus_din(bus_din), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n), .bus_adv_n(bus_adv_n)
  );

endmodule

// File: tb/tb_xbus_ctrl.sv
`timescale 1ns/1ps
module tb_xbus_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [2:0]  req_cs = '0;
  logic [8:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_cs = '0;
  logic [3:0]  cfg_field = '0;
  logic [7:0]  cfg_value = '0;
  logic [5:0]  bus_cs_n;
  logic [8:0]  bus_addr;
  logic [15:0] bus_dout;
  logic        bus_doe;
  logic [15:0] bus_din;
  logic        bus_oe_n, bus_we_n, bus_adv_n;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  function automatic logic [15:0] mem_word(logic [8:0] a);
    return {a[3:0], a, 3'b101} ^ 16'h1234;
  endfunction

  assign bus_din = !bus_oe_n ? mem_word(bus_addr) : 16'hDEAD;

  xbus_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cfg_we(cfg_we), .cfg_cs(cfg_cs), .cfg_field(cfg_field), .cfg_value(cfg_value),
    .bus_cs_n(bus_cs_n), .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .bus_din(bus_din), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n), .bus_adv_n(bus_adv_n)
  );

  // bench model of the timing fields and sequencing state
  int  m_rw[6], m_ww[6], m_rf[6], m_wf[6], m_rc[6], m_wh[6], m_rh[6], m_ao[6], m_ah[6];
  bit  m_first[6];
  bit  m_last_rd = 0;
  int  m_last_cs = 0;
  int  m_last_rc = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic cfg_write(input int cs, input int field, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_cs = cs[2:0]; cfg_field = field[3:0]; cfg_value = val[7:0];
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    if (cs < 6) begin
      case (field)
        0: m_rw[cs] = val & 15;
        1: m_ww[cs] = val & 15;
        2: m_rf[cs] = val & 255;
        3: m_wf[cs] = val & 255;
        4: m_rc[cs] = val & 15;
        5: m_wh[cs] = val & 15;
        6: m_rh[cs] = val & 15;
        7: m_ao[cs] = val & 3;
        8: m_ah[cs] = val & 1;
        default: ;
      endcase
    end
  endtask

  task automatic access(input bit wr, input int cs, input int addr, input int data);
    int e_rec, e_set, e_str, e_hold;
    int rec, setup, strb, hold, advc, adv_pos, act;
    bit need, got, bad_cs, bad_doe, bad_rdy, bad_data, bad_strb;
    logic [15:0] rd;
    logic rdy_at_rsp;
    need  = m_last_rd && ((cs != m_last_cs) || wr);
    e_rec = need ? ((m_last_rc == 0) ? 1 : m_last_rc) : 0;
    if (wr) begin
      e_set  = 0;
      e_str  = m_ww[cs] + 1 + (m_first[cs] ? m_wf[cs] : 0);
      e_hold = m_wh[cs] + 1;
    end else begin
      e_set  = ((m_rh[cs] > m_ao[cs]) ? m_rh[cs] : m_ao[cs]) + m_ah[cs];
      e_str  = m_rw[cs] + 1 + (m_first[cs] ? m_rf[cs] : 0);
      e_hold = 0;
    end
    rec = 0; setup = 0; strb = 0; hold = 0; advc = 0; adv_pos = -1; act = 0;
    got = 0; bad_cs = 0; bad_doe = 0; bad_rdy = 0; bad_data = 0; bad_strb = 0;
    rd = '0; rdy_at_rsp = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11", "ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_write = wr; req_cs = cs[2:0];
    req_addr = addr[8:0]; req_wdata = data[15:0];
    @(posedge clk);
    for (int i = 0; i < 700 && !got; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (rsp_valid) begin
        got = 1; rd = rsp_rdata; rdy_at_rsp = req_ready;
      end else begin
        if (req_ready) bad_rdy = 1;
        if (!bus_adv_n) advc++;
        if (bus_cs_n == 6'h3F) begin
          rec++;
          if (bus_doe || !bus_oe_n || !bus_we_n) bad_doe = 1;
        end else begin
          if (bus_cs_n != ~(6'd1 << cs)) bad_cs = 1;
          if (!bus_adv_n && adv_pos < 0) adv_pos = act;
          act++;
          if (bus_doe != wr) bad_doe = 1;
          if (bus_addr != addr[8:0]) bad_data = 1;
          if (wr && bus_dout != data[15:0]) bad_data = 1;
          if (!bus_oe_n || !bus_we_n) begin
            strb++;
            if (wr ? !bus_oe_n : !bus_we_n) bad_strb = 1;
          end else if (strb == 0) setup++;
          else hold++;
        end
      end
    end
    chk(got, "R10", "response seen", int'(got), 1);
    chk(rec == e_rec, "R6", "recovery cycles", rec, e_rec);
    chk(setup == e_set, "R2", "setup cycles", setup, e_set);
    if (wr) chk(strb == e_str, "R4", "write strobe cycles", strb, e_str);
    else    chk(strb == e_str, "R3", "read strobe cycles", strb, e_str);
    chk(hold == e_hold, "R5", "write hold cycles", hold, e_hold);
    chk(!bad_cs, "R1", "chip select pattern", int'(bad_cs), 0);
    chk(advc == 1 && adv_pos == 0, "R8", "address valid count", advc, 1);
    chk(!bad_doe && !bad_strb, "R9", "output enable usage", int'(bad_doe), 0);
    chk(!bad_data, "R9", "address/data on bus", int'(bad_data), 0);
    chk(!bad_rdy && rdy_at_rsp, "R11", "ready low while busy", int'(bad_rdy), 0);
    if (!wr) chk(rd == mem_word(addr[8:0]), "R10", "read data",
                 int'(rd), int'(mem_word(addr[8:0])));
    @(negedge clk);
    chk(!rsp_valid, "R10", "response pulse width", int'(rsp_valid), 0);
    for (int k = 0; k < 6; k++) m_first[k] = (k != cs);
    m_last_rd = !wr; m_last_cs = cs; m_last_rc = m_rc[cs];
  endtask

  task automatic t_reset;
    chk(req_ready && !rsp_valid, "R13", "ready/rsp after reset", int'(req_ready), 1);
    chk(bus_cs_n == 6'h3F, "R13", "chip selects after reset", int'(bus_cs_n), 63);
    chk(bus_oe_n && bus_we_n && bus_adv_n && !bus_doe, "R13", "strobes after reset",
        int'({bus_oe_n, bus_we_n, bus_adv_n, bus_doe}), 14);
  endtask

  task automatic t_program;
    cfg_write(0, 0, 1);  cfg_write(0, 2, 4);
    cfg_write(1, 0, 3);  cfg_write(1, 2, 5);  cfg_write(1, 6, 2);
    cfg_write(1, 7, 3);  cfg_write(1, 8, 1);
    cfg_write(1, 1, 2);  cfg_write(1, 3, 7);  cfg_write(1, 5, 3);
    cfg_write(4, 2, 10); cfg_write(4, 4, 5);  cfg_write(4, 3, 6); cfg_write(4, 1, 1);
    cfg_write(3, 1, 4);  cfg_write(3, 3, 9);  cfg_write(3, 5, 0); cfg_write(3, 6, 5);
    cfg_write(5, 7, 2);
  endtask

  // R7: first read after reset carries the latency, second does not
  task automatic t_first_read;
    access(0, 0, 9'h012, 0);
    access(0, 0, 9'h1FF, 0);
  endtask

  // R2/R3: setup from read hold, adv spacing and address hold
  task automatic t_read_setup;
    access(0, 1, 9'h0A5, 0);
    access(0, 1, 9'h100, 0);
  endtask

  // R6: read followed by write on the same select, zero recovery gives one
  task automatic t_turn_write;
    access(1, 1, 9'h033, 16'hBEEF);
  endtask

  // R6: after a write no recovery; read to another select after read uses its count
  task automatic t_recov_other;
    access(0, 4, 9'h044, 0);
    access(0, 5, 9'h155, 0);
    access(0, 4, 9'h066, 0);
    access(1, 4, 9'h077, 16'h0F0F);
  endtask

  // R12: writes naming a select beyond the last one are dropped
  task automatic t_cfg_ignore;
    cfg_write(6, 0, 15);
    cfg_write(7, 0, 15);
    cfg_write(6, 2, 200);
    access(0, 0, 9'h088, 0);
  endtask

  // R4/R5/R7: back-to-back writes, only the first pays the latency
  task automatic t_writes;
    access(1, 3, 9'h000, 16'h1234);
    access(1, 3, 9'h1FE, 16'hFFFF);
    access(0, 3, 9'h0C3, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R11 watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int k = 0; k < 6; k++) begin
      m_rw[k] = 0; m_ww[k] = 0; m_rf[k] = 0; m_wf[k] = 0; m_rc[k] = 0;
      m_wh[k] = 0; m_rh[k] = 0; m_ao[k] = 0; m_ah[k] = 0; m_first[k] = 1;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_first_read();
    t_read_setup();
    t_turn_write();
    t_recov_other();
    t_cfg_ignore();
    t_writes();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule